// File: doc/BRIEF.md
# Descriptor Link Reload Sequencer

This block keeps a small bank of transfer descriptors and one active descriptor for a single DMA channel. Each descriptor carries a synchronization mode, a source and a destination address, three nested counts, two signed step values for each address, a link index and a completion code. The data mover is not part of the block. For each trigger the block sends out one transfer request that names a source, a destination and a byte count. It then steps the counts and the addresses of the active descriptor.

When the outermost count runs out, the block raises a completion pulse that carries the descriptor's code. If the link index names a stored set, that set is copied over the active descriptor in the following cycle. The copy does not start a transfer; the channel waits for its next trigger. Two stored sets that link to each other therefore alternate the destination buffer with no help from software.

Top module: `dma_link_reload`

## Requirements
- R1: After reset, trValid and doneValid are low, and triggers produce no request until an active descriptor with a nonzero C count is written.
- R2: In frame mode (abSync=1), each trigger issues one request of aCnt*bCnt bytes and decrements the C count by one. After the request, the source and destination advance by their C steps.
- R3: In array mode (abSync=0), each trigger issues one request of aCnt bytes and decrements the B count. When the B count was 1, it reloads to its programmed value and the C count decrements instead. A request that does not end a frame advances both addresses by their B steps. A request that ends a frame advances them by their C steps.
- R4: The request that drives the C count to zero raises doneValid in the same cycle as its trValid, with doneCode equal to the descriptor's code. No other request raises doneValid.
- R5: On completion, when the link field is not all ones (7), the stored set it names replaces the active descriptor one cycle later.
- R6: A link reload issues no request. trValid stays low in the reload cycle.
- R7: When the link field is all ones (7), the active descriptor keeps a zero C count and later triggers issue no request.
- R8: A trigger that arrives in the reload cycle is held. It is served with the reloaded descriptor one cycle after the reload.
- R9: trValid is a one-cycle pulse, and each accepted trigger gives exactly one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Transfer trigger, one per cycle |
| wrEn | input | 1 | Descriptor write strobe |
| wrActive | input | 1 | 1: write the active descriptor; 0: write stored set wrIdx |
| wrIdx | input | 3 | Stored set index |
| wrAbSync | input | 1 | 1 frame mode, 0 array mode |
| wrSrc | input | 16 | Source address |
| wrDst | input | 16 | Destination address |
| wrACnt | input | 8 | Bytes per array |
| wrBCnt | input | 8 | Arrays per frame |
| wrCCnt | input | 8 | Frames per transfer |
| wrSrcBIdx | input | 8 | Signed source step between arrays |
| wrSrcCIdx | input | 8 | Signed source step between frames |
| wrDstBIdx | input | 8 | Signed destination step between arrays |
| wrDstCIdx | input | 8 | Signed destination step between frames |
| wrLink | input | 3 | Linked set index, 7 = none |
| wrCode | input | 6 | Completion code |
| trValid | output | 1 | Transfer request pulse |
| trSrc | output | 16 | Request source address |
| trDst | output | 16 | Request destination address |
| trBytes | output | 16 | Request byte count |
| doneValid | output | 1 | Completion pulse |
| doneCode | output | 6 | Completion code of the finished descriptor |

## Verification
A ping-pong walk through two linked frame-mode sets shows that the destination alternates between buffers and that the completion codes switch with it. It also shows that the reload cycle stays quiet. A back-to-back trigger placed on the reload cycle tells a held trigger apart from a dropped one, and it shows whether the held trigger is served with the old descriptor or the new one. An array-mode run with no link checks the B-count wrap and the choice between the B step and the C step. It also checks that the channel stays dead after completion.

// File: rtl/dma_link_pkg.sv
package dma_link_pkg;
  parameter int ADDR_W = 16;
  parameter int CNT_W  = 8;
  parameter int IDX_W  = 8;
  parameter int LINK_W = 3;
  parameter int CODE_W = 6;
  localparam int NUM_SETS = 2 ** LINK_W;
  localparam int BYTES_W  = 2 * CNT_W;
  localparam logic [LINK_W-1:0] NO_LINK = '1;

  typedef struct packed {
    logic              abSync;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [CNT_W-1:0]  aCnt;
    logic [CNT_W-1:0]  bCnt;
    logic [CNT_W-1:0]  cCnt;
    logic [IDX_W-1:0]  srcBIdx;
    logic [IDX_W-1:0]  srcCIdx;
    logic [IDX_W-1:0]  dstBIdx;
    logic [IDX_W-1:0]  dstCIdx;
    logic [LINK_W-1:0] link;
    logic [CODE_W-1:0] code;
  } desc_t;

  typedef struct packed {
    logic issue;
    logic reload;
  } strobe_t;
endpackage

// File: rtl/pset_ctrl.sv
module pset_ctrl
  import dma_link_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    trig,
  input  logic    live,
  input  logic    lastReq,
  input  logic    linkValid,
  output strobe_t strobe
);
  typedef enum logic {S_IDLE, S_RELOAD} state_t;
  state_t state;
  logic pending;
  logic want;

  assign want          = trig | pending;
  assign strobe.issue  = (state == S_IDLE) && want && live;
  assign strobe.reload = (state == S_RELOAD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pending <= 1'b0;
    end else if (state == S_RELOAD) begin
      state   <= S_IDLE;
      pending <= pending | trig;
    end else begin
      pending <= live & trig & pending;
      if (strobe.issue && lastReq && linkValid) state <= S_RELOAD;
    end
  end

  AST_RELOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> !strobe.reload); // R5
  AST_NO_ISSUE_IN_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |-> !strobe.issue); // R6
  AST_HELD_SERVED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.reload && trig) |=> (strobe.issue || !live)); // R8
endmodule

// File: rtl/pset_datapath.sv
module pset_datapath
  import dma_link_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic               wrEn,
  input  logic               wrActive,
  input  logic [LINK_W-1:0]  wrIdx,
  input  desc_t              wrDesc,
  output logic               live,
  output logic               lastReq,
  output logic               linkValid,
  output logic               trValid,
  output logic [ADDR_W-1:0]  trSrc,
  output logic [ADDR_W-1:0]  trDst,
  output logic [BYTES_W-1:0] trBytes,
  output logic               doneValid,
  output logic [CODE_W-1:0]  doneCode
);
  desc_t            mem [NUM_SETS];
  desc_t            act;
  logic [CNT_W-1:0] bRld;
  logic             frameEnd;
  logic [IDX_W-1:0] srcStep, dstStep;

  function automatic logic [ADDR_W-1:0] stepAddr(logic [ADDR_W-1:0] a, logic [IDX_W-1:0] s);
    return a + {{(ADDR_W-IDX_W){s[IDX_W-1]}}, s};
  endfunction

  assign live      = act.cCnt != '0;
  assign frameEnd  = act.abSync || (act.bCnt == CNT_W'(1));
  assign lastReq   = frameEnd && (act.cCnt == CNT_W'(1));
  assign linkValid = act.link != NO_LINK;
  assign srcStep   = frameEnd ? act.srcCIdx : act.srcBIdx;
  assign dstStep   = frameEnd ? act.dstCIdx : act.dstBIdx;

  genvar g;
  generate
    for (g = 0; g < NUM_SETS; g++) begin : g_set
      always_ff @(posedge clk) begin
        if (!rstN) mem[g] <= '0;
        else if (wrEn && !wrActive && wrIdx == LINK_W'(g)) mem[g] <= wrDesc;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      act      <= '0;
      act.link <= NO_LINK;
      bRld     <= '0;
    end else if (strobe.reload) begin
      act  <= mem[act.link];
      bRld <= mem[act.link].bCnt;
    end else if (strobe.issue) begin
      act.src <= stepAddr(act.src, srcStep);
      act.dst <= stepAddr(act.dst, dstStep);
      if (frameEnd) begin
        act.cCnt <= act.cCnt - CNT_W'(1);
        if (!act.abSync) act.bCnt <= bRld;
      end else begin
        act.bCnt <= act.bCnt - CNT_W'(1);
      end
    end else if (wrEn && wrActive) begin
      act  <= wrDesc;
      bRld <= wrDesc.bCnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trValid   <= 1'b0;
      trSrc     <= '0;
      trDst     <= '0;
      trBytes   <= '0;
      doneValid <= 1'b0;
      doneCode  <= '0;
    end else begin
      trValid   <= strobe.issue;
      doneValid <= strobe.issue && lastReq;
      if (strobe.issue) begin
        trSrc   <= act.src;
        trDst   <= act.dst;
        trBytes <= act.abSync ? BYTES_W'(act.aCnt) * BYTES_W'(act.bCnt) : BYTES_W'(act.aCnt);
        if (lastReq) doneCode <= act.code;
      end
    end
  end

  AST_DONE_WITH_REQ: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> trValid); // R4
  AST_ISSUE_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |-> live); // R7
  AST_FRAME_DECR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && act.abSync) |=> (act.cCnt == $past(act.cCnt) - CNT_W'(1))); // R2
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (trValid && !$past(strobe.issue)) |-> 1'b0); // R9
endmodule

// File: rtl/dma_link_reload.sv
module dma_link_reload
  import dma_link_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               trig,
  input  logic               wrEn,
  input  logic               wrActive,
  input  logic [LINK_W-1:0]  wrIdx,
  input  logic               wrAbSync,
  input  logic [ADDR_W-1:0]  wrSrc,
  input  logic [ADDR_W-1:0]  wrDst,
  input  logic [CNT_W-1:0]   wrACnt,
  input  logic [CNT_W-1:0]   wrBCnt,
  input  logic [CNT_W-1:0]   wrCCnt,
  input  logic [IDX_W-1:0]   wrSrcBIdx,
  input  logic [IDX_W-1:0]   wrSrcCIdx,
  input  logic [IDX_W-1:0]   wrDstBIdx,
  input  logic [IDX_W-1:0]   wrDstCIdx,
  input  logic [LINK_W-1:0]  wrLink,
  input  logic [CODE_W-1:0]  wrCode,
  output logic               trValid,
  output logic [ADDR_W-1:0]  trSrc,
  output logic [ADDR_W-1:0]  trDst,
  output logic [BYTES_W-1:0] trBytes,
  output logic               doneValid,
  output logic [CODE_W-1:0]  doneCode
);
  strobe_t strobe;
  desc_t   wrDesc;
  logic    live, lastReq, linkValid;

  assign wrDesc = '{abSync: wrAbSync, src: wrSrc, dst: wrDst, aCnt: wrACnt,
                    bCnt: wrBCnt, cCnt: wrCCnt, srcBIdx: wrSrcBIdx,
                    srcCIdx: wrSrcCIdx, dstBIdx: wrDstBIdx, dstCIdx: wrDstCIdx,
                    link: wrLink, code: wrCode};

  pset_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .trig(trig), .live(live), .lastReq(lastReq),
    .linkValid(linkValid), .strobe(strobe)
  );

  pset_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEn(wrEn), .wrActive(wrActive),
    .wrIdx(wrIdx), .wrDesc(wrDesc), .live(live), .lastReq(lastReq),
    .linkValid(linkValid), .trValid(trValid), .trSrc(trSrc), .trDst(trDst),
    .trBytes(trBytes), .doneValid(doneValid), .doneCode(doneCode)
  );
endmodule

// File: tb/dma_link_reload_test.sv
`timescale 1ns/1ps
module dma_link_reload_test;
  logic clk = 1'b0, rstN = 1'b0, trig = 1'b0;
  logic wrEn = 1'b0, wrActive = 1'b0, wrAbSync = 1'b0;
  logic [2:0] wrIdx = '0, wrLink = '0;
  logic [15:0] wrSrc = '0, wrDst = '0;
  logic [7:0] wrACnt = '0, wrBCnt = '0, wrCCnt = '0;
  logic [7:0] wrSrcBIdx = '0, wrSrcCIdx = '0, wrDstBIdx = '0, wrDstCIdx = '0;
  logic [5:0] wrCode = '0, doneCode;
  logic trValid, doneValid;
  logic [15:0] trSrc, trDst, trBytes;
  int applied = 0, miss = 0;

  always #2 clk = ~clk;

  dma_link_reload uut (
    .clk(clk), .rstN(rstN), .trig(trig), .wrEn(wrEn), .wrActive(wrActive),
    .wrIdx(wrIdx), .wrAbSync(wrAbSync), .wrSrc(wrSrc), .wrDst(wrDst),
    .wrACnt(wrACnt), .wrBCnt(wrBCnt), .wrCCnt(wrCCnt), .wrSrcBIdx(wrSrcBIdx),
    .wrSrcCIdx(wrSrcCIdx), .wrDstBIdx(wrDstBIdx), .wrDstCIdx(wrDstCIdx),
    .wrLink(wrLink), .wrCode(wrCode), .trValid(trValid), .trSrc(trSrc),
    .trDst(trDst), .trBytes(trBytes), .doneValid(doneValid), .doneCode(doneCode)
  );

  // {dst, bytes, done, code} for the ping-pong walk
  localparam logic [47:0] VEC [6] = '{
    {16'h1000, 16'd8, 8'd0, 8'd0},
    {16'h1008, 16'd8, 8'd1, 8'd5},
    {16'h2000, 16'd8, 8'd0, 8'd0},
    {16'h2008, 16'd8, 8'd1, 8'd6},
    {16'h1000, 16'd8, 8'd0, 8'd0},
    {16'h1008, 16'd8, 8'd1, 8'd5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeDesc(input logic act, input logic [2:0] idx, input logic ab,
      input logic [15:0] s, input logic [15:0] d, input logic [7:0] a,
      input logic [7:0] b, input logic [7:0] c, input logic [7:0] sb,
      input logic [7:0] sc, input logic [7:0] db, input logic [7:0] dc,
      input logic [2:0] lk, input logic [5:0] cd);
    @(negedge clk);
    wrEn = 1'b1; wrActive = act; wrIdx = idx; wrAbSync = ab; wrSrc = s; wrDst = d;
    wrACnt = a; wrBCnt = b; wrCCnt = c; wrSrcBIdx = sb; wrSrcCIdx = sc;
    wrDstBIdx = db; wrDstCIdx = dc; wrLink = lk; wrCode = cd;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulse();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miss++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miss);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 trValid", 32'(trValid), 0);
    check("R1 doneValid", 32'(doneValid), 0);
    pulse();
    check("R1 empty trig", 32'(trValid), 0);

    // ping set 1, pong set 2, frame mode; active starts as ping
    writeDesc(1'b0, 3'd1, 1'b1, 16'h0040, 16'h1000, 8'd4, 8'd2, 8'd2, 8'd0, 8'd0, 8'd0, 8'd8, 3'd2, 6'd5);
    writeDesc(1'b0, 3'd2, 1'b1, 16'h0040, 16'h2000, 8'd4, 8'd2, 8'd2, 8'd0, 8'd0, 8'd0, 8'd8, 3'd1, 6'd6);
    writeDesc(1'b1, 3'd0, 1'b1, 16'h0040, 16'h1000, 8'd4, 8'd2, 8'd2, 8'd0, 8'd0, 8'd0, 8'd8, 3'd2, 6'd5);

    for (int i = 0; i < 6; i++) begin
      pulse();
      check("R9 trValid", 32'(trValid), 1);
      check("R2 dst", 32'(trDst), 32'(VEC[i][47:32]));
      check("R2 bytes", 32'(trBytes), 32'(VEC[i][31:16]));
      check("R2 src", 32'(trSrc), 32'h40);
      check("R4 done", 32'(doneValid), 32'(VEC[i][8]));
      if (VEC[i][8]) check("R4 code", 32'(doneCode), 32'(VEC[i][5:0]));
      @(negedge clk);
      check("R6 quiet", 32'(trValid), 0);
    end

    // R5 R8: active now pong; trigger lands on reload cycle
    pulse();
    check("R5 pong dst", 32'(trDst), 32'h2000);
    trig = 1'b1;
    @(negedge clk);
    check("R4 last", 32'(doneValid), 1);
    @(negedge clk);
    trig = 1'b0;
    check("R6 reload quiet", 32'(trValid), 0);
    @(negedge clk);
    check("R8 held served", 32'(trValid), 1);
    check("R8 reloaded dst", 32'(trDst), 32'h1000);
    @(negedge clk);
    check("R9 single", 32'(trValid), 0);

    // R3 R7: array mode, no link
    writeDesc(1'b1, 3'd0, 1'b0, 16'h0100, 16'h3000, 8'd4, 8'd2, 8'd2, 8'd4, 8'd16, 8'd1, 8'hFE, 3'd7, 6'd9);
    pulse();
    check("R3 src0", 32'(trSrc), 32'h100);
    check("R3 bytes", 32'(trBytes), 4);
    pulse();
    check("R3 src1", 32'(trSrc), 32'h104);
    check("R3 dst1", 32'(trDst), 32'h3001);
    check("R3 not done", 32'(doneValid), 0);
    pulse();
    check("R3 src2", 32'(trSrc), 32'h114);
    check("R3 dst2", 32'(trDst), 32'h2FFF);
    pulse();
    check("R3 src3", 32'(trSrc), 32'h118);
    check("R4 done", 32'(doneValid), 1);
    check("R4 code", 32'(doneCode), 9);
    @(negedge clk);
    pulse();
    check("R7 ignored", 32'(trValid), 0);
    pulse();
    check("R7 still ignored", 32'(doneValid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miss);
    $finish;
  end
endmodule